// File: doc/BRIEF.md
# Field Memory Start-Up Sequencer

This block brings a serial field memory from power-on to a usable state. The memory has separate write and read ports. Each port has its own clock and its own pointer-reset strobe. After a start request is accepted while the supply is reported good, the block waits a settling interval counted in system clock cycles. It then enables a burst of dummy clocks on both ports and places the pointer-reset strobes in the order the memory needs. When both ports have finished, it raises a sticky ready level.

Each port runs its own small sequencer, and both sequencers are launched in the same cycle. There are two modes, latched when the request is accepted. In the plain mode, each port gets a run of dummy clocks followed by one reset strobe. The recovery mode is for cases where the supply may not have been settled while the dummy clocks ran. In that mode each port gets a reset strobe, then a run of dummy clocks, then a second strobe. One asserted cycle of a clock enable corresponds to one port clock. Each strobe lasts one system cycle, which corresponds to one port clock.

Top module: `fieldmem_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is low after that edge, and `init_done` stays low until a full sequence completes.
- R2: The settle length is S = ceil(CLK_HZ × SETTLE_US / 1 000 000) cycles, with a minimum of 1. The first port activity (an enable, or a strobe in recovery mode) appears exactly S cycles after the cycle in which the start request was accepted.
- R3: The write and read sequences are launched in the same cycle and run concurrently.
- R4: In plain mode, each port shows exactly its configured number of contiguous enable cycles (WR_DUMMY for write, RD_DUMMY for read), then exactly one reset strobe.
- R5: In recovery mode, each port shows one reset strobe, then its configured number of contiguous enable cycles, then a second reset strobe, with no enable before the first strobe or after the second.
- R6: Every reset strobe is high for exactly one cycle and is never high in a cycle where the same port's clock enable is high.
- R7: `init_done` rises two cycles after the later of the two ports' final strobes. It then stays high until reset, and no enable or strobe is active while it is high.
- R8: A start request is ignored while a sequence is running and after `init_done` is set.
- R9: `recover` is sampled only in the cycle the start request is accepted; later changes have no effect on the running sequence.
- R10: A start request is accepted only when `pwr_ok` is high; a request made with `pwr_ok` low starts nothing, even after `pwr_ok` later rises.
- R11: If `pwr_ok` is low at any edge during the settle wait, the wait restarts. The first activity then appears S cycles after the first cycle in which `pwr_ok` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supply reported stable |
| start | input | 1 | Request to run the start-up sequence |
| recover | input | 1 | Select bracketed recovery mode (sampled at start) |
| mem_wclk_en | output | 1 | Write-port clock enable; each high cycle is one dummy write clock |
| mem_rclk_en | output | 1 | Read-port clock enable; each high cycle is one dummy read clock |
| wr_ptr_rst | output | 1 | Write-pointer reset strobe |
| rd_ptr_rst | output | 1 | Read-pointer reset strobe |
| init_done | output | 1 | Sticky ready level |

## Verification
Because the two ports are launched together, a write-port event and a read-port event regularly fall in the same cycle. The dummy bursts begin together, and in recovery mode both leading strobes coincide. The bench gives the ports different burst lengths, so one port's final strobe lands while the other port is still clocking. It then judges each port separately against its own count, checks the same-cycle start, and confirms that the ready level waits for the later port. A second collision is provoked on purpose: a start request is issued mid-sequence and again after completion, and the bench confirms that the running pattern and the ready level are unchanged.

// File: rtl/fmi_pkg.sv
// Package: shared types, port indices and the settle-length helper for
// the field memory start-up sequencer.
package fmi_pkg;

    localparam int PORT_WR   = 0;
    localparam int PORT_RD   = 1;
    localparam int NUM_PORTS = 2;

    typedef enum logic [1:0] {
        TOP_IDLE,
        TOP_SETTLE,
        TOP_RUN,
        TOP_DONE
    } top_state_t;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_LEAD_RST,
        PS_DUMMY,
        PS_TAIL_RST,
        PS_DONE
    } port_state_t;

    // Cycles needed to cover settle_us microseconds at hz, rounded up, min 1.
    function automatic int unsigned settle_cycles(longint unsigned hz,
                                                  longint unsigned settle_us);
        longint unsigned prod;
        longint unsigned cyc;
        prod = hz * settle_us;
        cyc  = (prod + 64'd999_999) / 64'd1_000_000;
        if (cyc == 64'd0) begin
            cyc = 64'd1;
        end
        return 32'(cyc);
    endfunction

endpackage

// File: rtl/fmi_settle_timer.sv
// Module: settle interval timer.
// Counts CYCLES enabled edges and flags the last one. A clear input holds
// the count at zero, so any interruption restarts the full interval.
// Assumes CYCLES >= 1.
module fmi_settle_timer #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expire
);

    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // Last counted edge of the interval.
    assign expire = en && !clr && (cnt == LAST);

    // Interval counter: cleared on clr, wraps to zero on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= expire ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/fmi_port_seq.sv
// Module: per-port start-up sequencer.
// On go it runs either the plain pattern (DUMMY_CYC enable cycles, then
// one strobe) or the bracketed pattern (strobe, DUMMY_CYC enable cycles,
// strobe), then holds done. Assumes DUMMY_CYC >= 1; go is a one-cycle
// pulse and is acted on only while idle.
module fmi_port_seq #(
    parameter int unsigned DUMMY_CYC = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic recover,
    output logic clk_en,
    output logic rst_strobe,
    output logic done
);

    import fmi_pkg::*;

    localparam int unsigned CW = $clog2(DUMMY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DUMMY_CYC - 1);

    port_state_t state, state_nx;
    logic [CW-1:0] cnt;
    logic          burst_last;

    // Final enable cycle of the dummy burst.
    assign burst_last = (state == PS_DUMMY) && (cnt == LAST);

    // Next-state selection for the port pattern.
    always_comb begin
        state_nx = state;
        case (state)
            PS_IDLE:     if (go) state_nx = recover ? PS_LEAD_RST : PS_DUMMY;
            PS_LEAD_RST: state_nx = PS_DUMMY;
            PS_DUMMY:    if (burst_last) state_nx = PS_TAIL_RST;
            PS_TAIL_RST: state_nx = PS_DONE;
            PS_DONE:     state_nx = PS_DONE;
            default:     state_nx = PS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Burst counter: counts enable cycles, idle at zero elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == PS_DUMMY && !burst_last) begin
            cnt <= cnt + CW'(1);
        end else begin
            cnt <= '0;
        end
    end

    // Outputs decode directly from the registered state.
    assign clk_en     = (state == PS_DUMMY);
    assign rst_strobe = (state == PS_LEAD_RST) || (state == PS_TAIL_RST);
    assign done       = (state == PS_DONE);

endmodule

// File: rtl/fieldmem_init_seq.sv
// Module: field memory start-up sequencer (top).
// Accepts a start request while pwr_ok is high, waits the settle interval
// derived from CLK_HZ and SETTLE_US (restarting if pwr_ok drops), then
// launches the write and read port sequencers together in the latched
// mode and raises a sticky init_done once both have finished. Assumes one
// enable cycle equals one port clock at the memory.
module fieldmem_init_seq #(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SETTLE_US = 100,
    parameter int unsigned WR_DUMMY  = 130,
    parameter int unsigned RD_DUMMY  = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic start,
    input  logic recover,
    output logic mem_wclk_en,
    output logic mem_rclk_en,
    output logic wr_ptr_rst,
    output logic rd_ptr_rst,
    output logic init_done
);

    import fmi_pkg::*;

    localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_US);

    top_state_t state;
    logic       mode_q;
    logic       accept;
    logic       settle_clr;
    logic       settle_en;
    logic       settle_expire;
    logic [NUM_PORTS-1:0] port_en;
    logic [NUM_PORTS-1:0] port_rst;
    logic [NUM_PORTS-1:0] port_done;

    // Start is taken only from idle with the supply good.
    assign accept = (state == TOP_IDLE) && start && pwr_ok;

    // Settle timer runs in SETTLE and restarts whenever pwr_ok is low.
    assign settle_en  = (state == TOP_SETTLE);
    assign settle_clr = (state != TOP_SETTLE) || !pwr_ok;

    fmi_settle_timer #(
        .CYCLES (SETTLE_CYC)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (settle_clr),
        .en     (settle_en),
        .expire (settle_expire)
    );

    // Top-level phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TOP_IDLE;
        end else begin
            case (state)
                TOP_IDLE:   if (accept) state <= TOP_SETTLE;
                TOP_SETTLE: if (settle_expire) state <= TOP_RUN;
                TOP_RUN:    if (&port_done) state <= TOP_DONE;
                TOP_DONE:   state <= TOP_DONE;
                default:    state <= TOP_IDLE;
            endcase
        end
    end

    // Mode latch: recover is captured only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (accept) begin
            mode_q <= recover;
        end
    end

    // One sequencer per port, both launched by the settle expiry.
    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        localparam int unsigned N = (gp == PORT_WR) ? WR_DUMMY : RD_DUMMY;
        fmi_port_seq #(
            .DUMMY_CYC (N)
        ) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .go         (settle_expire),
            .recover    (mode_q),
            .clk_en     (port_en[gp]),
            .rst_strobe (port_rst[gp]),
            .done       (port_done[gp])
        );
    end

    assign mem_wclk_en = port_en[PORT_WR];
    assign mem_rclk_en = port_en[PORT_RD];
    assign wr_ptr_rst  = port_rst[PORT_WR];
    assign rd_ptr_rst  = port_rst[PORT_RD];
    assign init_done   = (state == TOP_DONE);

endmodule

// Checker: port-level properties of the sequencer, bound to the top.
module fmi_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic mem_wclk_en,
    input logic mem_rclk_en,
    input logic wr_ptr_rst,
    input logic rd_ptr_rst,
    input logic init_done
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !(init_done || mem_wclk_en || mem_rclk_en || wr_ptr_rst || rd_ptr_rst));

    assert_wr_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ptr_rst && mem_wclk_en));

    assert_rd_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ptr_rst && mem_rclk_en));

    assert_wr_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr_rst |=> !wr_ptr_rst);

    assert_rd_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_rst |=> !rd_ptr_rst);

    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !(mem_wclk_en || mem_rclk_en || wr_ptr_rst || rd_ptr_rst));

    assert_start_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && start) |=> (init_done && !mem_wclk_en && !mem_rclk_en));

endmodule

bind fieldmem_init_seq fmi_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mem_wclk_en (mem_wclk_en),
    .mem_rclk_en (mem_rclk_en),
    .wr_ptr_rst  (wr_ptr_rst),
    .rd_ptr_rst  (rd_ptr_rst),
    .init_done   (init_done)
);

// File: tb/fieldmem_init_seq_bench.sv
// Directed bench for the field memory start-up sequencer.
module fieldmem_init_seq_bench;

    localparam int unsigned CLK_HZ = 10_000_005;
    localparam int S_EXP = 1001;   // ceil(10_000_005 * 100 / 1e6), R2
    localparam int N_WR  = 130;
    localparam int N_RD  = 136;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0;
    logic start = 1'b0;
    logic recover = 1'b0;
    logic mem_wclk_en, mem_rclk_en, wr_ptr_rst, rd_ptr_rst, init_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fieldmem_init_seq #(
        .CLK_HZ    (CLK_HZ),
        .SETTLE_US (100),
        .WR_DUMMY  (N_WR),
        .RD_DUMMY  (N_RD)
    ) u_fieldmem_init_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_ok      (pwr_ok),
        .start       (start),
        .recover     (recover),
        .mem_wclk_en (mem_wclk_en),
        .mem_rclk_en (mem_rclk_en),
        .wr_ptr_rst  (wr_ptr_rst),
        .rd_ptr_rst  (rd_ptr_rst),
        .init_done   (init_done)
    );

    // Activity tracker, sampled at the falling edge. Index 0 write, 1 read.
    bit trk_on = 1'b0;
    int first_en[2], first_rst[2], last_rst[2], nrst[2], ovl[2], dbl[2];
    int seg_en[2][4];
    bit prev_rs[2];
    int first_ready, quiet_bad;

    task automatic clear_trk();
        for (int p = 0; p < 2; p++) begin
            first_en[p] = -1; first_rst[p] = -1; last_rst[p] = -1;
            nrst[p] = 0; ovl[p] = 0; dbl[p] = 0; prev_rs[p] = 1'b0;
            for (int s = 0; s < 4; s++) seg_en[p][s] = 0;
        end
        first_ready = -1;
        quiet_bad = 0;
    endtask

    always @(negedge clk) begin
        if (trk_on) begin
            for (int p = 0; p < 2; p++) begin
                bit en, rs;
                en = (p == 0) ? mem_wclk_en : mem_rclk_en;
                rs = (p == 0) ? wr_ptr_rst : rd_ptr_rst;
                if (en && first_en[p] < 0) first_en[p] = cyc;
                if (rs && first_rst[p] < 0) first_rst[p] = cyc;
                if (en) seg_en[p][nrst[p]] = seg_en[p][nrst[p]] + 1;
                if (en && rs) ovl[p] = ovl[p] + 1;
                if (rs) begin
                    if (prev_rs[p]) dbl[p] = dbl[p] + 1;
                    if (nrst[p] < 3) nrst[p] = nrst[p] + 1;
                    last_rst[p] = cyc;
                end
                prev_rs[p] = rs;
            end
            if (init_done && first_ready < 0) first_ready = cyc;
            if (init_done && (mem_wclk_en || mem_rclk_en || wr_ptr_rst || rd_ptr_rst))
                quiet_bad = quiet_bad + 1;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulse start for one edge; returns the cycle index of the accepting edge.
    task automatic pulse_start(input bit mode, output int t0);
        @(negedge clk);
        start = 1'b1;
        recover = mode;
        @(negedge clk);
        start = 1'b0;
        recover = ~mode;
        t0 = cyc;
    endtask

    task automatic wait_ready(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (init_done) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        idle(4);
        chk("R1", "outputs in reset",
            {mem_wclk_en, mem_rclk_en, wr_ptr_rst, rd_ptr_rst, init_done}, 0);
        rst_n = 1'b1;
        idle(5);
        chk("R1", "outputs idle after reset",
            {mem_wclk_en, mem_rclk_en, wr_ptr_rst, rd_ptr_rst, init_done}, 0);
    endtask

    task automatic t_normal();
        int t0, t1;
        clear_trk();
        trk_on = 1'b1;
        pwr_ok = 1'b1;
        pulse_start(1'b0, t0);
        idle(500);
        pulse_start(1'b1, t1);   // mid-run request, must be ignored (R8, R9)
        wait_ready(3000);
        idle(40);
        chk("R2", "settle latency write", first_en[0] - t0, S_EXP);
        chk("R3", "read starts with write", first_en[1], first_en[0]);
        chk("R4", "write dummy count", seg_en[0][0], N_WR);
        chk("R4", "read dummy count", seg_en[1][0], N_RD);
        chk("R4", "write strobes", nrst[0], 1);
        chk("R8", "read strobes after mid-run start", nrst[1], 1);
        chk("R4", "write enables after strobe", seg_en[0][1], 0);
        chk("R6", "overlap", ovl[0] + ovl[1], 0);
        chk("R6", "strobe width", dbl[0] + dbl[1], 0);
        chk("R7", "ready timing", first_ready, max2(last_rst[0], last_rst[1]) + 2);
        chk("R7", "ready quiet", quiet_bad, 0);
        chk("R7", "ready held", init_done, 1);
        trk_on = 1'b0;
    endtask

    task automatic t_after_done();
        int t0;
        clear_trk();
        trk_on = 1'b1;
        pulse_start(1'b0, t0);
        pulse_start(1'b1, t0);
        idle(S_EXP + 200);
        chk("R8", "activity after done",
            seg_en[0][0] + seg_en[1][0] + nrst[0] + nrst[1], 0);
        chk("R8", "ready kept", init_done, 1);
        trk_on = 1'b0;
        do_reset();
        @(negedge clk);
        chk("R1", "reset clears ready", init_done, 0);
    endtask

    task automatic t_recovery();
        int t0;
        clear_trk();
        trk_on = 1'b1;
        pwr_ok = 1'b1;
        pulse_start(1'b1, t0);   // recover drops right after acceptance (R9)
        wait_ready(3000);
        idle(20);
        chk("R5", "lead strobe latency", first_rst[0] - t0, S_EXP);
        chk("R3", "read lead strobe same cycle", first_rst[1], first_rst[0]);
        chk("R5", "write enables before lead", seg_en[0][0], 0);
        chk("R9", "write bracketed count", seg_en[0][1], N_WR);
        chk("R5", "read bracketed count", seg_en[1][1], N_RD);
        chk("R5", "enables after tail", seg_en[0][2] + seg_en[1][2], 0);
        chk("R5", "write strobes", nrst[0], 2);
        chk("R5", "read strobes", nrst[1], 2);
        chk("R6", "overlap", ovl[0] + ovl[1], 0);
        chk("R6", "strobe width", dbl[0] + dbl[1], 0);
        chk("R7", "ready timing", first_ready, max2(last_rst[0], last_rst[1]) + 2);
        trk_on = 1'b0;
    endtask

    task automatic t_no_power();
        int t0;
        do_reset();
        clear_trk();
        trk_on = 1'b1;
        pwr_ok = 1'b0;
        pulse_start(1'b0, t0);
        idle(20);
        pwr_ok = 1'b1;
        idle(S_EXP + 50);
        chk("R10", "activity without accepted start",
            seg_en[0][0] + seg_en[1][0] + nrst[0] + nrst[1], 0);
        chk("R10", "no ready", init_done, 0);
        trk_on = 1'b0;
    endtask

    task automatic t_power_drop();
        int t0, traise;
        clear_trk();
        trk_on = 1'b1;
        pwr_ok = 1'b1;
        pulse_start(1'b0, t0);
        idle(300);
        pwr_ok = 1'b0;
        @(negedge clk);
        pwr_ok = 1'b1;
        traise = cyc;
        wait_ready(3000);
        idle(5);
        chk("R11", "restart latency", first_en[0] - traise, S_EXP);
        chk("R11", "read restart latency", first_en[1] - traise, S_EXP);
        chk("R4", "write count after restart", seg_en[0][0], N_WR);
        chk("R4", "read count after restart", seg_en[1][0], N_RD);
        chk("R7", "ready reached", init_done, 1);
        trk_on = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        clear_trk();
        t_reset();
        t_normal();
        t_after_done();
        t_recovery();
        t_no_power();
        t_power_drop();
        summary();
    end

endmodule